// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column addresses one bank walks through during a burst. A mode word sets the burst length and the ordering, and the block stores it. A read or write command then loads a starting column. From that point the block gives out one column per clock, until the programmed length is used up. A full-page burst does not stop by itself: it runs until it is stopped or restarted.

Finite bursts stay inside an aligned block of N columns. In sequential order the low log2(N) bits count up and wrap. In interleaved order those bits are the start column XOR the beat index. A new command in the middle of a burst drops the rest of the old burst and starts a new burst of the full length. A stop request ends only a full-page burst. In any other mode the stop request raises a one-cycle error flag and has no other effect.

All outputs are registered. The surrounding controller uses `col_out` while `col_valid` is high.

Top module: `burst_col_gen`

## Requirements
- R1: After a synchronous reset, `col_valid`, `col_last` and `stop_err` are 0 and `col_out` is 0.
- R2: A clock edge with `cmd_start` high makes `col_out` equal to `start_col` and `col_valid` high on the following cycle, whatever state the block was in.
- R3: `mode_word[2:0]` sets the length: 0→1, 1→2, 2→4, 3→8, 7→full page. The reserved codes 4–6 act as length 1. A finite burst keeps `col_valid` high for exactly N cycles.
- R4: With `mode_word[3]`=0 (sequential), each beat adds one to the low log2(N) bits with wrap-around, and the upper column bits keep the start value.
- R5: With `mode_word[3]`=1 (interleaved), the low log2(N) bits of beat k equal the start column's low bits XOR k, and the upper bits keep the start value.
- R6: `col_last` is high only on the final beat of a finite burst. It is never high during a full-page burst.
- R7: A full-page burst counts up by one per cycle modulo 256 and wraps from 255 to 0. It uses sequential order even when `mode_word[3]`=1.
- R8: A command that arrives during a burst restarts the count at the new column with the full programmed length.
- R9: A stop request during a full-page burst drops `col_valid` on the next cycle. When the programmed length is not full page, the stop request does not change the burst, and `stop_err` is high for one cycle.
- R10: A burst keeps the mode that was stored when it started. A mode write during a burst takes effect only at the next command.
- R11: After a finite burst ends, `col_valid` stays low until the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Store `mode_word` at this edge |
| mode_word | input | 4 | [3] ordering (1 = interleaved), [2:0] length code |
| cmd_start | input | 1 | Read or write command; loads `start_col` |
| start_col | input | 8 | Starting column for the burst |
| stop_req | input | 1 | Request to end a full-page burst |
| col_out | output | 8 | Current column |
| col_valid | output | 1 | `col_out` is part of a burst |
| col_last | output | 1 | Final beat of a finite burst |
| stop_err | output | 1 | Stop request was made in a non-full-page mode |

## Verification
The hardest cases to reach are the ones where two events meet in a single cycle. One is a restart that lands in the middle of a burst. Another is a mode write made while a burst is still running. A third is a stop request made during a finite burst. The bench drives each of these from a negative edge, at a chosen beat. It then follows every later beat at the ports, so it can see that the count started over with the full length, that the stored mode was kept, and that the stopped burst went on unchanged.

// File: rtl/col_gen_pkg.sv
package col_gen_pkg;

  typedef struct packed {
    logic       ilv;
    logic [2:0] len;
  } burst_mode_t;

  localparam logic [2:0] LEN_FULL = 3'd7;

  // Mask of the column bits that step within one burst; wide enough for 16-bit columns.
  function automatic logic [15:0] beat_mask(input logic [2:0] code);
    case (code)
      3'd1:    beat_mask = 16'h0001;
      3'd2:    beat_mask = 16'h0003;
      3'd3:    beat_mask = 16'h0007;
      3'd7:    beat_mask = 16'hFFFF;
      default: beat_mask = 16'h0000;
    endcase
  endfunction

  function automatic logic is_full(input logic [2:0] code);
    is_full = (code == LEN_FULL);
  endfunction

endpackage

// File: rtl/col_mode_reg.sv
module col_mode_reg
  import col_gen_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        we,
  input  burst_mode_t wdata,
  output burst_mode_t mode
);
  always_ff @(posedge clk) begin
    if (rst)     mode <= '0;
    else if (we) mode <= wdata;
  end
endmodule

// File: rtl/col_addr_form.sv
module col_addr_form
  import col_gen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] idx,
  input  burst_mode_t      mode,
  output logic [COL_W-1:0] col
);
  logic [15:0]      mask_w;
  logic [COL_W-1:0] mask;
  logic [COL_W-1:0] low;

  assign mask_w = beat_mask(mode.len);
  assign mask   = mask_w[COL_W-1:0];

  always_comb begin
    if (mode.ilv && !is_full(mode.len)) low = base ^ idx;
    else                                low = base + idx;
    col = (base & ~mask) | (low & mask);
  end
endmodule

// File: rtl/col_beat_ctl.sv
module col_beat_ctl
  import col_gen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             stop_req,
  input  burst_mode_t      mode_prog,
  input  logic [COL_W-1:0] next_col,
  output logic [COL_W-1:0] base_q,
  output logic [COL_W-1:0] idx_next,
  output burst_mode_t      mode_q,
  output logic [COL_W-1:0] col_q,
  output logic             valid_q,
  output logic             last_q,
  output logic             err_q
);
  logic [COL_W-1:0] idx_q;
  logic [15:0]      mq_w, mp_w;
  logic [COL_W-1:0] mask_q, mask_p;
  logic             full_q;

  assign mq_w     = beat_mask(mode_q.len);
  assign mp_w     = beat_mask(mode_prog.len);
  assign mask_q   = mq_w[COL_W-1:0];
  assign mask_p   = mp_w[COL_W-1:0];
  assign full_q   = is_full(mode_q.len);
  assign idx_next = idx_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      idx_q   <= '0;
      mode_q  <= '0;
      col_q   <= '0;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      err_q <= stop_req && !is_full(mode_prog.len);
      if (start) begin
        base_q  <= start_col;
        idx_q   <= '0;
        mode_q  <= mode_prog;
        col_q   <= start_col;
        valid_q <= 1'b1;
        last_q  <= !is_full(mode_prog.len) && (mask_p == '0);
      end else if (valid_q) begin
        if (full_q) begin
          if (stop_req) valid_q <= 1'b0;
          else begin
            idx_q <= idx_next;
            col_q <= next_col;
          end
        end else if (last_q) begin
          valid_q <= 1'b0;
          last_q  <= 1'b0;
        end else begin
          idx_q  <= idx_next;
          col_q  <= next_col;
          last_q <= (idx_next == mask_q);
        end
      end
    end
  end

  p_start_loads_r2: assert property (@(posedge clk) disable iff (rst)
    start |=> valid_q && col_q == $past(start_col));
  p_last_in_burst_r6: assert property (@(posedge clk) disable iff (rst)
    last_q |-> valid_q && !full_q);
  p_drain_r11: assert property (@(posedge clk) disable iff (rst)
    valid_q && last_q && !start |=> !valid_q);
  p_full_step_r7: assert property (@(posedge clk) disable iff (rst)
    valid_q && full_q && !start && !stop_req |=> valid_q && col_q == COL_W'($past(col_q) + 1'b1));
  p_stop_ends_r9: assert property (@(posedge clk) disable iff (rst)
    valid_q && full_q && stop_req && !start |=> !valid_q);
  p_upper_hold_r4: assert property (@(posedge clk) disable iff (rst)
    valid_q && !full_q && !last_q && !start |=> (col_q | mask_q) == ($past(col_q) | mask_q));
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import col_gen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_we,
  input  logic [3:0]       mode_word,
  input  logic             cmd_start,
  input  logic [COL_W-1:0] start_col,
  input  logic             stop_req,
  output logic [COL_W-1:0] col_out,
  output logic             col_valid,
  output logic             col_last,
  output logic             stop_err
);
  burst_mode_t      mode_prog, mode_q, wdata;
  logic [COL_W-1:0] base_q, idx_next, next_col;

  assign wdata = '{ilv: mode_word[3], len: mode_word[2:0]};

  col_mode_reg u_mode (
    .clk(clk), .rst(rst), .we(mode_we), .wdata(wdata), .mode(mode_prog)
  );

  col_addr_form #(.COL_W(COL_W)) u_form (
    .base(base_q), .idx(idx_next), .mode(mode_q), .col(next_col)
  );

  col_beat_ctl #(.COL_W(COL_W)) u_ctl (
    .clk(clk), .rst(rst), .start(cmd_start), .start_col(start_col),
    .stop_req(stop_req), .mode_prog(mode_prog), .next_col(next_col),
    .base_q(base_q), .idx_next(idx_next), .mode_q(mode_q),
    .col_q(col_out), .valid_q(col_valid), .last_q(col_last), .err_q(stop_err)
  );

  p_err_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    stop_err && !stop_req |=> !stop_err);
endmodule

// File: tb/burst_col_gen_bench.sv
module burst_col_gen_bench;
  logic       clk = 0, rst = 1;
  logic       mode_we = 0, cmd_start = 0, stop_req = 0;
  logic [3:0] mode_word = 0;
  logic [7:0] start_col = 0;
  logic [7:0] col_out;
  logic       col_valid, col_last, stop_err;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  burst_col_gen u_burst_col_gen (
    .clk(clk), .rst(rst), .mode_we(mode_we), .mode_word(mode_word),
    .cmd_start(cmd_start), .start_col(start_col), .stop_req(stop_req),
    .col_out(col_out), .col_valid(col_valid), .col_last(col_last), .stop_err(stop_err)
  );

  typedef struct packed {
    logic [3:0]  mode;
    logic [7:0]  col;
    logic [3:0]  len;
    logic [63:0] exp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{4'h3, 8'h2D, 4'd8, 64'h2C2B2A29282F2E2D},  // R4 seq 8
    '{4'hB, 8'h2D, 4'd8, 64'h2A2B28292E2F2C2D},  // R5 ilv 8
    '{4'h2, 8'h47, 4'd4, 64'h0000000046454447},  // R4 seq 4
    '{4'hA, 8'h47, 4'd4, 64'h0000000044454647},  // R5 ilv 4
    '{4'h1, 8'hFF, 4'd2, 64'h000000000000FEFF},  // R4 seq 2
    '{4'h9, 8'h10, 4'd2, 64'h0000000000001110},  // R5 ilv 2
    '{4'h0, 8'h99, 4'd1, 64'h0000000000000099},  // R3 len 1
    '{4'h5, 8'h3C, 4'd1, 64'h000000000000003C}   // R3 reserved code
  };

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic set_mode(logic [3:0] m);
    mode_we = 1; mode_word = m; tick(); mode_we = 0;
  endtask

  task automatic start(logic [7:0] c);
    cmd_start = 1; start_col = c; tick(); cmd_start = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); tick(); tick();
    // R1 reset state
    chk("R1 valid", col_valid, 0); chk("R1 last", col_last, 0);
    chk("R1 col", col_out, 0);     chk("R1 err", stop_err, 0);
    rst = 0; @(negedge clk);

    // Table walk: R3 R4 R5 R6 R11
    foreach (VECS[i]) begin
      set_mode(VECS[i].mode);
      start(VECS[i].col);
      for (int k = 0; k < int'(VECS[i].len); k++) begin
        chk("R3 valid", col_valid, 1);
        chk("R4/R5 col", col_out, int'(VECS[i].exp[k*8 +: 8]));
        chk("R6 last", col_last, (k == int'(VECS[i].len) - 1) ? 1 : 0);
        tick();
      end
      chk("R11 idle", col_valid, 0); tick();
      chk("R11 idle2", col_valid, 0);
    end

    // R7 full page wrap, interleave bit ignored
    set_mode(4'hF);
    start(8'hFE);
    chk("R7 c0", col_out, 8'hFE); tick();
    chk("R7 c1", col_out, 8'hFF); tick();
    chk("R7 wrap", col_out, 8'h00); chk("R6 nolast", col_last, 0); tick();
    chk("R7 c3", col_out, 8'h01); chk("R7 valid", col_valid, 1);
    // R9 stop in full page
    stop_req = 1; tick(); stop_req = 0;
    chk("R9 stopped", col_valid, 0); chk("R9 noerr", stop_err, 0);

    // R9 stop in finite mode is ignored, error pulses
    set_mode(4'h3);
    start(8'h00); tick(); tick();
    chk("R9 pre", col_out, 8'h02);
    stop_req = 1; tick(); stop_req = 0;
    chk("R9 err", stop_err, 1); chk("R9 kept", col_valid, 1); chk("R9 col", col_out, 8'h03);
    tick();
    chk("R9 errpulse", stop_err, 0); chk("R9 col2", col_out, 8'h04);
    repeat (4) tick();
    chk("R9 end", col_valid, 0);

    // R8 restart mid-burst with full length
    set_mode(4'h2);
    start(8'h10);
    chk("R8 b0", col_out, 8'h10); tick();
    chk("R8 b1", col_out, 8'h11);
    start(8'h22);
    chk("R8 n0", col_out, 8'h22); chk("R8 nolast", col_last, 0); tick();
    chk("R8 n1", col_out, 8'h23); tick();
    chk("R8 n2", col_out, 8'h20); tick();
    chk("R8 n3", col_out, 8'h21); chk("R8 last", col_last, 1); tick();
    chk("R8 end", col_valid, 0);

    // R10 mode write during a burst waits for the next command
    set_mode(4'h1);
    start(8'h50);
    mode_we = 1; mode_word = 4'h3; tick(); mode_we = 0;
    chk("R10 b1", col_out, 8'h51); chk("R10 last", col_last, 1); tick();
    chk("R10 end", col_valid, 0);
    start(8'h60);
    chk("R10 newlen", col_last, 0); repeat (7) tick();
    chk("R10 b7", col_out, 8'h67); chk("R10 last8", col_last, 1);

    // R2 start right on a last beat
    start(8'h81);
    chk("R2 col", col_out, 8'h81); chk("R2 valid", col_valid, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule